// File: doc/BRIEF.md
# Spike-Event Pixel Histogram Accumulator

This block turns a stream of pixel address-events from one spiking vision sensor into a frame-like intensity map. Each event carries a column and a row coordinate. Events enter a small queue that absorbs bursts. An update engine takes one queued event per cycle and performs a read-modify-write on the matching cell of a count memory. The count in each cell grows with the firing rate of its pixel.

The count memory has a second, independent read port for a search engine. That engine can look up any cell while events are still being counted. A frame timer fires every `FRAME_CYCLES` clock cycles, for example every 20 ms to give about 50 frames per second. On each firing the engine finishes the event it is processing and then writes zero to every cell in turn. Events that arrive during this sweep wait in the queue. A stereo system uses one instance per sensor.

The coordinate width is a parameter. A full 128×128 sensor uses `COORD_W` = 7. The default keeps the memory small.

Top module: `evt_hist_accum`

## Requirements
- R1: During reset and directly after it, `clr_busy` is 1 and `ovf_flag` is 0. Once `clr_busy` falls, every cell reads 0.
- R2: Each accepted event adds one to the cell at address {row, column}. A read with `rd_en` high returns that cell's count on `rd_data` in the cycle after the request.
- R3: A count stops at 2^CNT_W−1 (255 for 8-bit cells). Further events leave it unchanged and never wrap it to zero.
- R4: Events to the same cell on consecutive cycles are all counted. No count is lost in the read-modify-write pipeline.
- R5: The queue accepts at most one event per cycle. While no clear is pending or running, the update side drains one event per cycle and never pops an empty queue.
- R6: The queue holds 2^FIFO_AW events. An event presented while the queue is full is discarded and sets `ovf_flag`. The flag stays at 1 until reset.
- R7: `clr_busy` rises once every `FRAME_CYCLES` cycles. When it falls again, every cell from the previous frame reads 0.
- R8: Events that arrive while `clr_busy` is 1 are held in the queue. They are counted after the sweep ends. The sweep writes the cell addresses in ascending order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | An address-event is present this cycle |
| evt_x | input | COORD_W | Column of the event |
| evt_y | input | COORD_W | Row of the event |
| ovf_flag | output | 1 | Sticky flag: an event was dropped because the queue was full |
| rd_en | input | 1 | Search-side read request |
| rd_x | input | COORD_W | Column to read |
| rd_y | input | COORD_W | Row to read |
| rd_data | output | CNT_W | Cell count, valid the cycle after `rd_en` |
| clr_busy | output | 1 | A frame clear is pending or running |

## Verification
The bench uses an 8×8 map and a 4-entry queue. It loads every cell with a count taken from its own coordinates and sends each cell's events back to back. A design that dropped the forwarded value would come up short on every cell that gets more than one event. A stream of 260 events to a single cell must read exactly 255; an adder that wraps would show a small residue instead. Six events pushed during a sweep must leave a count of exactly 4 and a raised flag. That catches a design that pops during the clear, accepts an event while full, or counts the event it dropped. The spacing between two frame clears is measured in cycles, and after each clear the map is swept for leftover counts.

// File: rtl/hist_pkg.sv
package hist_pkg;

  // Operating mode of the histogram update engine.
  typedef enum logic [1:0] {
    UPD_RUN   = 2'd0,  // popping events and counting
    UPD_DRAIN = 2'd1,  // clear requested, letting the pipeline empty
    UPD_SWEEP = 2'd2   // writing zero to every cell
  } upd_mode_e;

  // Linear cell index of a pixel: row in the upper half, column in the lower.
  function automatic int unsigned cell_index(input int unsigned col,
                                             input int unsigned row,
                                             input int unsigned coord_w);
    return (row << coord_w) | col;
  endfunction

endpackage

// File: rtl/hist_evt_fifo.sv
module hist_evt_fifo #(
  parameter int DW = 10,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          ovf
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] slots [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          full;
  logic          push_ok;
  logic          drop_evt;

  assign full     = (count == (AW+1)'(DEPTH));
  assign empty    = (count == '0);
  assign push_ok  = push_req && !full;
  assign drop_evt = push_req && full;
  assign dout     = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop)     rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (drop_evt) ovf <= 1'b1;
    end
  end

  // R5: the consumer never pops an empty queue
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R6: overflow flag is sticky until reset
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R6: occupancy never exceeds the capacity
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));

endmodule

// File: rtl/hist_cell_ram.sv
module hist_cell_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          ua_en,
  input  logic [AW-1:0] ua_addr,
  output logic [DW-1:0] ua_q,
  input  logic          sb_en,
  input  logic [AW-1:0] sb_addr,
  output logic [DW-1:0] sb_q
);
  localparam int CELLS = 1 << AW;

  logic [DW-1:0] cells [CELLS];

  // Update side: one write, one registered read (returns the old value on collision).
  always_ff @(posedge clk) begin
    if (we)    cells[waddr] <= wdata;
    if (ua_en) ua_q <= cells[ua_addr];
  end

  // Search side: independent registered read.
  always_ff @(posedge clk) begin
    if (sb_en) sb_q <= cells[sb_addr];
  end

endmodule

// File: rtl/hist_frame_timer.sv
module hist_frame_timer #(
  parameter int FRAME_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(FRAME_CYCLES - 1);

  logic [TW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R7: ticks are isolated single-cycle pulses
  a_r7_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (FRAME_CYCLES > 1) && tick |=> !tick);

endmodule

// File: rtl/hist_updater.sv
module hist_updater
  import hist_pkg::*;
#(
  parameter int AW    = 10,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             q_empty,
  input  logic [AW-1:0]    q_head,
  output logic             q_pop,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  input  logic [CNT_W-1:0] rd_q,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [CNT_W-1:0] wdata,
  output logic             busy
);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + CNT_W'(1);
  endfunction

  upd_mode_e        mode;
  logic             s1_valid;
  logic [AW-1:0]    s1_addr;
  logic             lw_valid;
  logic [AW-1:0]    lw_addr;
  logic [CNT_W-1:0] lw_data;
  logic [AW-1:0]    sweep_addr;
  logic             sweeping;
  logic             fwd_hit;
  logic [CNT_W-1:0] base_val;
  logic [CNT_W-1:0] upd_wdata;

  assign sweeping  = (mode == UPD_SWEEP);
  assign busy      = (mode != UPD_RUN);
  assign q_pop     = (mode == UPD_RUN) && !q_empty;
  assign rd_en     = q_pop;
  assign rd_addr   = q_head;

  // Forward the value written last cycle: the memory read issued then saw the old data.
  assign fwd_hit   = lw_valid && (lw_addr == s1_addr);
  assign base_val  = fwd_hit ? lw_data : rd_q;
  assign upd_wdata = sat_inc(base_val);

  assign we    = s1_valid || sweeping;
  assign waddr = sweeping ? sweep_addr : s1_addr;
  assign wdata = sweeping ? '0 : upd_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= UPD_DRAIN;
      s1_valid   <= 1'b0;
      s1_addr    <= '0;
      lw_valid   <= 1'b0;
      lw_addr    <= '0;
      lw_data    <= '0;
      sweep_addr <= '0;
    end else begin
      s1_valid <= q_pop;
      if (q_pop) s1_addr <= q_head;
      lw_valid <= s1_valid;
      lw_addr  <= s1_addr;
      lw_data  <= upd_wdata;
      case (mode)
        UPD_RUN: if (tick) mode <= UPD_DRAIN;
        UPD_DRAIN: if (!s1_valid) begin
          mode       <= UPD_SWEEP;
          sweep_addr <= '0;
        end
        UPD_SWEEP: begin
          if (tick)              sweep_addr <= '0;
          else if (&sweep_addr)  mode <= UPD_RUN;
          else                   sweep_addr <= sweep_addr + 1'b1;
        end
        default: mode <= UPD_DRAIN;
      endcase
    end
  end

  // R8: no event is in flight while the sweep writes zeros
  a_r8_sweep_excl: assert property (@(posedge clk) disable iff (!rst_n)
    sweeping |-> !s1_valid);

  // R8: sweep visits addresses in ascending order
  a_r8_sweep_order: assert property (@(posedge clk) disable iff (!rst_n)
    sweeping && $past(sweeping) && !$past(tick) |-> sweep_addr == $past(sweep_addr) + 1'b1);

  // R3: an increment never yields zero (no wrap)
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> upd_wdata != '0);

  // R5: queue is not popped while a clear is pending or running
  a_r5_no_pop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !q_pop);

endmodule

// File: rtl/evt_hist_accum.sv
module evt_hist_accum #(
  parameter int COORD_W      = 5,
  parameter int CNT_W        = 8,
  parameter int FIFO_AW      = 4,
  parameter int FRAME_CYCLES = 1000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid,
  input  logic [COORD_W-1:0] evt_x,
  input  logic [COORD_W-1:0] evt_y,
  output logic               ovf_flag,
  input  logic               rd_en,
  input  logic [COORD_W-1:0] rd_x,
  input  logic [COORD_W-1:0] rd_y,
  output logic [CNT_W-1:0]   rd_data,
  output logic               clr_busy
);
  localparam int AW = 2 * COORD_W;

  logic          q_empty, q_pop;
  logic [AW-1:0] q_head;
  logic          u_rd_en;
  logic [AW-1:0] u_rd_addr;
  logic [CNT_W-1:0] u_rd_q;
  logic          m_we;
  logic [AW-1:0] m_waddr;
  logic [CNT_W-1:0] m_wdata;
  logic          frame_tick;

  hist_evt_fifo #(.DW(AW), .AW(FIFO_AW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_req(evt_valid), .din({evt_y, evt_x}),
    .pop(q_pop), .dout(q_head), .empty(q_empty), .ovf(ovf_flag)
  );

  hist_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick)
  );

  hist_updater #(.AW(AW), .CNT_W(CNT_W)) u_upd (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick),
    .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
    .rd_en(u_rd_en), .rd_addr(u_rd_addr), .rd_q(u_rd_q),
    .we(m_we), .waddr(m_waddr), .wdata(m_wdata), .busy(clr_busy)
  );

  hist_cell_ram #(.AW(AW), .DW(CNT_W)) u_ram (
    .clk(clk),
    .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
    .ua_en(u_rd_en), .ua_addr(u_rd_addr), .ua_q(u_rd_q),
    .sb_en(rd_en), .sb_addr({rd_y, rd_x}), .sb_q(rd_data)
  );

endmodule

// File: tb/tb_evt_hist_accum.sv
module tb_evt_hist_accum;
  localparam int CLK_PERIOD = 10;
  localparam int CW    = 3;
  localparam int CNTW  = 8;
  localparam int FAW   = 2;
  localparam int FC    = 2000;
  localparam int NCELL = 1 << (2 * CW);
  localparam int SIDE  = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0;
  logic [CW-1:0] evt_x = '0, evt_y = '0;
  logic ovf_flag;
  logic rd_en = 1'b0;
  logic [CW-1:0] rd_x = '0, rd_y = '0;
  logic [CNTW-1:0] rd_data;
  logic clr_busy;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int expv [NCELL];

  evt_hist_accum #(.COORD_W(CW), .CNT_W(CNTW), .FIFO_AW(FAW), .FRAME_CYCLES(FC)) dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_x(evt_x), .evt_y(evt_y),
    .ovf_flag(ovf_flag), .rd_en(rd_en), .rd_x(rd_x), .rd_y(rd_y),
    .rd_data(rd_data), .clr_busy(clr_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int x, input int y, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evt_valid = 1'b1; evt_x = CW'(x); evt_y = CW'(y);
    end
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic rd_cell(input int x, input int y, output int v);
    @(negedge clk);
    rd_en = 1'b1; rd_x = CW'(x); rd_y = CW'(y);
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic sweep_chk(input string req);
    int v;
    for (int y = 0; y < SIDE; y++)
      for (int x = 0; x < SIDE; x++) begin
        rd_cell(x, y, v);
        chk(req, v, expv[y*SIDE + x]);
      end
  endtask

  task automatic wait_rise(output int at);
    @(negedge clk);
    while (clr_busy) @(negedge clk);
    while (!clr_busy) @(negedge clk);
    at = cyc;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (clr_busy) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 60000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, 60000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int t_a, t_b, v;
    repeat (5) @(negedge clk);
    chk("R1 busy in reset", int'(clr_busy), 1);
    chk("R1 ovf in reset", int'(ovf_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(clr_busy), 1);
    chk("R1 ovf after reset", int'(ovf_flag), 0);
    wait_idle();

    // R1: power-up sweep leaves all zeros
    for (int i = 0; i < NCELL; i++) expv[i] = 0;
    sweep_chk("R1 initial clear");

    // R2/R4/R5: per-cell count from coordinates, sent back to back
    for (int y = 0; y < SIDE; y++)
      for (int x = 0; x < SIDE; x++) begin
        expv[y*SIDE + x] = (x + 2*y) % 5;
        if (expv[y*SIDE + x] > 0) send(x, y, expv[y*SIDE + x]);
      end
    repeat (6) @(negedge clk);
    sweep_chk("R2 R4 R5 pattern");
    chk("R6 no spurious ovf", int'(ovf_flag), 0);

    // R8/R6: events during the clear are queued; extras beyond depth dropped
    wait_rise(t_a);
    send(5, 6, 6);
    chk("R6 ovf raised", int'(ovf_flag), 1);
    wait_idle();
    for (int i = 0; i < NCELL; i++) expv[i] = 0;
    expv[6*SIDE + 5] = 1 << FAW;
    sweep_chk("R7 R8 clear and queued");

    // R3: saturation after a long same-cell stream
    send(7, 7, 260);
    send(0, 0, 3);
    repeat (6) @(negedge clk);
    rd_cell(7, 7, v); chk("R3 saturate", v, (1 << CNTW) - 1);
    rd_cell(0, 0, v); chk("R3 neighbour", v, 3);
    rd_cell(5, 6, v); chk("R8 queued kept", v, 1 << FAW);

    // R7: frame period
    wait_rise(t_b);
    chk("R7 period", t_b - t_a, FC);
    chk("R6 ovf sticky", int'(ovf_flag), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule